// File: doc/BRIEF.md
# Combined Read-Modify-Write Execution Unit

This unit computes the result of the six combined read-modify-write instructions of a classic 8-bit accumulator processor. Each of them first alters a memory operand (a shift, a rotate, an increment or a decrement). It then merges the altered byte into the accumulator with a logic, add or compare operation. For one request the unit takes the opcode, the byte already read from memory, the accumulator and the four status flags. It returns the byte to write back, the new accumulator value and the new flags. It also returns the instruction length in bytes and the bus cycle count of its addressing mode, which a bus sequencer uses to pace the access.

Requests use a registered handshake. A request is sampled on a rising edge while `req_valid` is high, and its result is presented on the response ports on the next cycle. The controller has two states. `ST_IDLE` means no result is pending. `ST_RESP` means a result is presented. A request moves `ST_IDLE` to `ST_RESP` (accept). A further request keeps `ST_RESP` (chain). A cycle without a request moves `ST_RESP` back to `ST_IDLE` (drain). Decimal arithmetic is not modelled.

Top module: `rmw_combo_unit`

## Requirements
- R1: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. Response data changes only on an accepted request and otherwise holds its last value.
- R2: An opcode is supported when bits [1:0] are 2'b11, bits [4:2] are not 3'b010, and bits [7:5] are one of 000 (shift-left-or), 001 (rotate-left-and), 010 (shift-right-xor), 011 (rotate-right-add), 110 (decrement-compare) or 111 (increment-subtract). This gives exactly 42 supported opcodes.
- R3: Bits [4:2] select the addressing mode, which sets length and cycle count: 001 zero page (2 bytes, 5 cycles), 101 zero page X (2, 6), 011 absolute (3, 6), 111 absolute X (3, 7), 110 absolute Y (3, 7), 000 indexed indirect (2, 8), 100 indirect indexed (2, 8).
- R4: Shift-left-or: the write byte is memory shifted left with a 0 in bit 0, and C takes the old bit 7. A becomes A OR write byte, and N and Z follow the new A.
- R5: Rotate-left-and: the write byte is memory rotated left with the old C entering bit 0, and C takes the old bit 7. A becomes A AND write byte, and N and Z follow A.
- R6: Shift-right-xor: the write byte is memory shifted right with a 0 in bit 7, and C takes the old bit 0. A becomes A XOR write byte, and N and Z follow A.
- R7: Rotate-right-add: the write byte is memory rotated right with the old C entering bit 7. A becomes A + write byte + old memory bit 0. C is the carry out, V is the signed overflow, and N and Z follow A.
- R8: Decrement-compare: the write byte is memory minus 1 and A is unchanged. C is set when A >= write byte (unsigned). N and Z come from A minus write byte.
- R9: Increment-subtract: the write byte is memory plus 1. A becomes A - write byte - (1 - C). C is set when no borrow occurs, V is the signed overflow, and N and Z follow A.
- R10: The flag bus is {N, V, Z, C} with N in bit 3 and C in bit 0. V passes through unchanged for R4, R5, R6 and R8.
- R11: For an unsupported opcode `rsp_illegal` is 1 and `rsp_wen` is 0. Length and cycles are 0, the write byte equals the memory input, and A and the flags are returned unchanged.
- R12: While `rst_n` is low, `rsp_valid` and all response data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_opcode | input | 8 | Instruction opcode |
| req_mem | input | 8 | Byte read from memory |
| req_acc | input | 8 | Current accumulator |
| req_flags | input | 4 | Current flags {N,V,Z,C} |
| rsp_valid | output | 1 | Result presented |
| rsp_wdata | output | 8 | Byte to write back |
| rsp_wen | output | 1 | Write-back required |
| rsp_acc | output | 8 | New accumulator |
| rsp_flags | output | 4 | New flags {N,V,Z,C} |
| rsp_len | output | 2 | Instruction length in bytes |
| rsp_cycles | output | 4 | Bus cycle count |
| rsp_illegal | output | 1 | Opcode not supported |

## Verification
Some rules are checked by the assertions on every cycle. These are the one-cycle response timing, the holding of results between requests, and the absence of write-back on an unsupported opcode. They also cover the pairing of length with cycle count, the preserved V flag of the non-arithmetic groups, and the unchanged accumulator of decrement-compare. The arithmetic itself can only be shown by the bench's scenarios. These cover carry chaining from the rotate into the add, signed overflow in both directions, borrow in the subtract, the compare's equal and less-than results, and the exact count of supported opcodes across all 256 encodings.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    // Encodings equal opcode bits [7:5] so that decode is a direct cast.
    typedef enum logic [2:0] {
        K_SLO = 3'd0,
        K_RLA = 3'd1,
        K_SRE = 3'd2,
        K_RRA = 3'd3,
        K_BAD = 3'd4,
        K_DCP = 3'd6,
        K_ISC = 3'd7
    } rmw_kind_e;

    // Encodings equal opcode bits [4:2].
    typedef enum logic [2:0] {
        M_INDX = 3'd0,
        M_ZP   = 3'd1,
        M_IMM  = 3'd2,
        M_ABS  = 3'd3,
        M_INDY = 3'd4,
        M_ZPX  = 3'd5,
        M_ABSY = 3'd6,
        M_ABSX = 3'd7
    } rmw_mode_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } rmw_flags_t;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } rmw_state_e;

endpackage

// File: rtl/rmw_decode.sv
module rmw_decode
    import rmw_pkg::*;
#(
    parameter int LEN_W = 2,
    parameter int CYC_W = 4
) (
    input  logic [7:0]       opcode,
    output rmw_kind_e        kind,
    output logic             legal,
    output logic [LEN_W-1:0] len,
    output logic [CYC_W-1:0] cycles
);

    rmw_mode_e mode;
    logic      shape_ok;

    assign mode     = rmw_mode_e'(opcode[4:2]);
    assign shape_ok = (opcode[1:0] == 2'b11) && (mode != M_IMM);

    always_comb begin
        kind = K_BAD;
        if (shape_ok) begin
            case (opcode[7:5])
                3'b000:  kind = K_SLO;
                3'b001:  kind = K_RLA;
                3'b010:  kind = K_SRE;
                3'b011:  kind = K_RRA;
                3'b110:  kind = K_DCP;
                3'b111:  kind = K_ISC;
                default: kind = K_BAD;
            endcase
        end
    end

    assign legal = (kind != K_BAD);

    always_comb begin
        len    = '0;
        cycles = '0;
        if (legal) begin
            case (mode)
                M_ZP:          begin len = LEN_W'(2); cycles = CYC_W'(5); end
                M_ZPX:         begin len = LEN_W'(2); cycles = CYC_W'(6); end
                M_ABS:         begin len = LEN_W'(3); cycles = CYC_W'(6); end
                M_ABSX, M_ABSY: begin len = LEN_W'(3); cycles = CYC_W'(7); end
                M_INDX, M_INDY: begin len = LEN_W'(2); cycles = CYC_W'(8); end
                default:       begin len = '0;        cycles = '0;        end
            endcase
        end
    end

endmodule

// File: rtl/rmw_mem_stage.sv
module rmw_mem_stage
    import rmw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rmw_kind_e         kind,
    input  logic [DATA_W-1:0] mem_in,
    input  logic              c_in,
    output logic [DATA_W-1:0] mem_new,
    output logic              c_mid
);

    always_comb begin
        mem_new = mem_in;
        c_mid   = c_in;
        case (kind)
            K_SLO:   {c_mid, mem_new} = {mem_in, 1'b0};
            K_RLA:   {c_mid, mem_new} = {mem_in, c_in};
            K_SRE:   {mem_new, c_mid} = {1'b0, mem_in};
            K_RRA:   {mem_new, c_mid} = {c_in, mem_in};
            K_DCP:   mem_new = mem_in - DATA_W'(1);
            K_ISC:   mem_new = mem_in + DATA_W'(1);
            default: begin
                mem_new = mem_in;
                c_mid   = c_in;
            end
        endcase
    end

endmodule

// File: rtl/rmw_acc_stage.sv
module rmw_acc_stage
    import rmw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rmw_kind_e         kind,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] mem_new,
    input  logic              c_mid,
    input  rmw_flags_t        flags_in,
    output logic [DATA_W-1:0] acc_new,
    output rmw_flags_t        flags_out
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0]   add_sum;
    logic [DATA_W:0]   sub_sum;
    logic              sub_cin;
    logic [DATA_W-1:0] nz_src;

    assign sub_cin = (kind == K_DCP) ? 1'b1 : flags_in.c;
    assign add_sum = {1'b0, acc_in} + {1'b0, mem_new} + (DATA_W+1)'(c_mid);
    assign sub_sum = {1'b0, acc_in} + {1'b0, ~mem_new} + (DATA_W+1)'(sub_cin);

    always_comb begin
        acc_new   = acc_in;
        flags_out = flags_in;
        nz_src    = acc_in;
        case (kind)
            K_SLO: begin
                acc_new     = acc_in | mem_new;
                nz_src      = acc_new;
                flags_out.c = c_mid;
            end
            K_RLA: begin
                acc_new     = acc_in & mem_new;
                nz_src      = acc_new;
                flags_out.c = c_mid;
            end
            K_SRE: begin
                acc_new     = acc_in ^ mem_new;
                nz_src      = acc_new;
                flags_out.c = c_mid;
            end
            K_RRA: begin
                acc_new     = add_sum[MSB:0];
                nz_src      = acc_new;
                flags_out.c = add_sum[DATA_W];
                flags_out.v = ~(acc_in[MSB] ^ mem_new[MSB]) & (acc_in[MSB] ^ add_sum[MSB]);
            end
            K_DCP: begin
                acc_new     = acc_in;
                nz_src      = sub_sum[MSB:0];
                flags_out.c = sub_sum[DATA_W];
            end
            K_ISC: begin
                acc_new     = sub_sum[MSB:0];
                nz_src      = acc_new;
                flags_out.c = sub_sum[DATA_W];
                flags_out.v = (acc_in[MSB] ^ mem_new[MSB]) & (acc_in[MSB] ^ sub_sum[MSB]);
            end
            default: begin
                acc_new   = acc_in;
                flags_out = flags_in;
                nz_src    = acc_in;
            end
        endcase
        if (kind != K_BAD) begin
            flags_out.n = nz_src[MSB];
            flags_out.z = (nz_src == '0);
        end
    end

endmodule

// File: rtl/rmw_combo_unit.sv
module rmw_combo_unit
    import rmw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2,
    parameter int CYC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [7:0]        req_opcode,
    input  logic [DATA_W-1:0] req_mem,
    input  logic [DATA_W-1:0] req_acc,
    input  logic [3:0]        req_flags,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_wdata,
    output logic              rsp_wen,
    output logic [DATA_W-1:0] rsp_acc,
    output logic [3:0]        rsp_flags,
    output logic [LEN_W-1:0]  rsp_len,
    output logic [CYC_W-1:0]  rsp_cycles,
    output logic              rsp_illegal
);

    rmw_state_e        state_q, state_d;
    rmw_kind_e         kind;
    logic              legal;
    logic [LEN_W-1:0]  len;
    logic [CYC_W-1:0]  cycles;
    logic [DATA_W-1:0] mem_new;
    logic              c_mid;
    logic [DATA_W-1:0] acc_new;
    rmw_flags_t        flags_in, flags_new;

    assign flags_in = rmw_flags_t'(req_flags);

    rmw_decode #(.LEN_W(LEN_W), .CYC_W(CYC_W)) u_decode (
        .opcode (req_opcode),
        .kind   (kind),
        .legal  (legal),
        .len    (len),
        .cycles (cycles)
    );

    rmw_mem_stage #(.DATA_W(DATA_W)) u_mem (
        .kind    (kind),
        .mem_in  (req_mem),
        .c_in    (flags_in.c),
        .mem_new (mem_new),
        .c_mid   (c_mid)
    );

    rmw_acc_stage #(.DATA_W(DATA_W)) u_acc (
        .kind      (kind),
        .acc_in    (req_acc),
        .mem_new   (mem_new),
        .c_mid     (c_mid),
        .flags_in  (flags_in),
        .acc_new   (acc_new),
        .flags_out (flags_new)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept (IDLE->RESP), chain (RESP->RESP), drain (RESP->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    assign rsp_valid = (state_q == ST_RESP);

    // Output registers: loaded only on an accepted request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_wdata   <= '0;
            rsp_wen     <= 1'b0;
            rsp_acc     <= '0;
            rsp_flags   <= '0;
            rsp_len     <= '0;
            rsp_cycles  <= '0;
            rsp_illegal <= 1'b0;
        end else if (req_valid) begin
            rsp_wdata   <= mem_new;
            rsp_wen     <= legal;
            rsp_acc     <= acc_new;
            rsp_flags   <= flags_new;
            rsp_len     <= len;
            rsp_cycles  <= cycles;
            rsp_illegal <= ~legal;
        end
    end

endmodule

// File: rtl/rmw_combo_checker.sv
module rmw_combo_checker #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2,
    parameter int CYC_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [7:0]        req_opcode,
    input logic [DATA_W-1:0] req_acc,
    input logic [3:0]        req_flags,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_wdata,
    input logic              rsp_wen,
    input logic [DATA_W-1:0] rsp_acc,
    input logic [3:0]        rsp_flags,
    input logic [LEN_W-1:0]  rsp_len,
    input logic [CYC_W-1:0]  rsp_cycles,
    input logic              rsp_illegal
);

    p_valid_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_after_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_hold_without_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_acc) && $stable(rsp_wdata) && $stable(rsp_flags)));

    p_no_write_on_bad_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_illegal) |-> (!rsp_wen && rsp_len == '0 && rsp_cycles == '0));

    p_len_cycle_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_illegal) |->
            ((rsp_len == LEN_W'(2) && (rsp_cycles == CYC_W'(5) || rsp_cycles == CYC_W'(6) ||
                                       rsp_cycles == CYC_W'(8))) ||
             (rsp_len == LEN_W'(3) && (rsp_cycles == CYC_W'(6) || rsp_cycles == CYC_W'(7)))));

    p_v_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_opcode[7:5] == 3'b000 || req_opcode[7:5] == 3'b001 ||
                       req_opcode[7:5] == 3'b010 || req_opcode[7:5] == 3'b110))
        |=> (rsp_flags[2] == $past(req_flags[2])));

    p_compare_keeps_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_opcode[7:5] == 3'b110) |=> (rsp_acc == $past(req_acc)));

endmodule

bind rmw_combo_unit rmw_combo_checker #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .CYC_W(CYC_W)
) u_rmw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_opcode  (req_opcode),
    .req_acc     (req_acc),
    .req_flags   (req_flags),
    .rsp_valid   (rsp_valid),
    .rsp_wdata   (rsp_wdata),
    .rsp_wen     (rsp_wen),
    .rsp_acc     (rsp_acc),
    .rsp_flags   (rsp_flags),
    .rsp_len     (rsp_len),
    .rsp_cycles  (rsp_cycles),
    .rsp_illegal (rsp_illegal)
);

// File: tb/rmw_combo_unit_bench.sv
module rmw_combo_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_opcode = '0;
    logic [7:0] req_mem = '0;
    logic [7:0] req_acc = '0;
    logic [3:0] req_flags = '0;
    logic       rsp_valid;
    logic [7:0] rsp_wdata;
    logic       rsp_wen;
    logic [7:0] rsp_acc;
    logic [3:0] rsp_flags;
    logic [1:0] rsp_len;
    logic [3:0] rsp_cycles;
    logic       rsp_illegal;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    rmw_combo_unit u_rmw_combo_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_mem(req_mem), .req_acc(req_acc), .req_flags(req_flags),
        .rsp_valid(rsp_valid), .rsp_wdata(rsp_wdata), .rsp_wen(rsp_wen),
        .rsp_acc(rsp_acc), .rsp_flags(rsp_flags), .rsp_len(rsp_len),
        .rsp_cycles(rsp_cycles), .rsp_illegal(rsp_illegal)
    );

    // {opcode, mem, acc, flags | exp wdata, exp acc, exp flags, wen, illegal, len, cycles}
    // flags are {N,V,Z,C}
    localparam int NV = 20;
    localparam logic [55:0] VECS [NV] = '{
        {8'h07, 8'h81, 8'h10, 4'h0,  8'h02, 8'h12, 4'h1, 1'b1, 1'b0, 2'd2, 4'd5},
        {8'h1F, 8'h40, 8'h00, 4'h4,  8'h80, 8'h80, 4'hC, 1'b1, 1'b0, 2'd3, 4'd7},
        {8'h37, 8'h80, 8'h01, 4'h1,  8'h01, 8'h01, 4'h1, 1'b1, 1'b0, 2'd2, 4'd6},
        {8'h23, 8'h55, 8'hAA, 4'h0,  8'hAA, 8'hAA, 4'h8, 1'b1, 1'b0, 2'd2, 4'd8},
        {8'h2F, 8'h0F, 8'hF0, 4'h0,  8'h1E, 8'h10, 4'h0, 1'b1, 1'b0, 2'd3, 4'd6},
        {8'h4F, 8'h03, 8'h01, 4'h0,  8'h01, 8'h00, 4'h3, 1'b1, 1'b0, 2'd3, 4'd6},
        {8'h53, 8'hFE, 8'hFF, 4'h4,  8'h7F, 8'h80, 4'hC, 1'b1, 1'b0, 2'd2, 4'd8},
        {8'h67, 8'h02, 8'h10, 4'h1,  8'h81, 8'h91, 4'h8, 1'b1, 1'b0, 2'd2, 4'd5},
        {8'h7B, 8'h01, 8'h7F, 4'h0,  8'h00, 8'h80, 4'hC, 1'b1, 1'b0, 2'd3, 4'd7},
        {8'h77, 8'hFF, 8'hFF, 4'h1,  8'hFF, 8'hFF, 4'h9, 1'b1, 1'b0, 2'd2, 4'd6},
        {8'hC7, 8'h05, 8'h04, 4'h0,  8'h04, 8'h04, 4'h3, 1'b1, 1'b0, 2'd2, 4'd5},
        {8'hCF, 8'h00, 8'h10, 4'h4,  8'hFF, 8'h10, 4'h4, 1'b1, 1'b0, 2'd3, 4'd6},
        {8'hC3, 8'h11, 8'h05, 4'h0,  8'h10, 8'h05, 4'h8, 1'b1, 1'b0, 2'd2, 4'd8},
        {8'hE7, 8'h0F, 8'h20, 4'h1,  8'h10, 8'h10, 4'h1, 1'b1, 1'b0, 2'd2, 4'd5},
        {8'hFF, 8'hFF, 8'h00, 4'h0,  8'h00, 8'hFF, 4'h8, 1'b1, 1'b0, 2'd3, 4'd7},
        {8'hF3, 8'h00, 8'h80, 4'h1,  8'h01, 8'h7F, 4'h5, 1'b1, 1'b0, 2'd2, 4'd8},
        {8'hFB, 8'h04, 8'h05, 4'h1,  8'h05, 8'h00, 4'h3, 1'b1, 1'b0, 2'd3, 4'd7},
        {8'hA7, 8'h33, 8'h44, 4'hA,  8'h33, 8'h44, 4'hA, 1'b0, 1'b1, 2'd0, 4'd0},
        {8'h0B, 8'h12, 8'h34, 4'h5,  8'h12, 8'h34, 4'h5, 1'b0, 1'b1, 2'd0, 4'd0},
        {8'hEA, 8'h9C, 8'h01, 4'h0,  8'h9C, 8'h01, 4'h0, 1'b0, 1'b1, 2'd0, 4'd0}
    };

    function automatic string tag_of(input logic [7:0] op);
        if (op[1:0] != 2'b11 || op[4:2] == 3'b010) return "R11";
        case (op[7:5])
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd6: return "R8";
            3'd7: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [55:0] v);
        req_valid  = 1'b1;
        req_opcode = v[55:48];
        req_mem    = v[47:40];
        req_acc    = v[39:32];
        req_flags  = v[31:28];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [27:0] got;
        int legal_cnt;
        int long_cnt;

        // R12: reset state
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0 && rsp_acc == 8'h00 && rsp_wen == 1'b0 && rsp_flags == 4'h0,
              "R12", {rsp_valid, rsp_wen, rsp_acc, rsp_flags}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table, issued back to back; each compare also covers R1, R3 and R10
        drive(VECS[0]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            got = {rsp_wdata, rsp_acc, rsp_flags, rsp_wen, rsp_illegal, rsp_len, rsp_cycles};
            check(rsp_valid == 1'b1, "R1", {31'd0, rsp_valid}, 32'd1);
            check(got == VECS[i][27:0], tag_of(VECS[i][55:48]), {4'd0, got},
                  {4'd0, VECS[i][27:0]});
            if (i + 1 < NV) drive(VECS[i + 1]);
            else            req_valid = 1'b0;
        end

        // R1: without a request the response drops and data holds, whatever the inputs
        req_opcode = 8'h07; req_mem = 8'hFF; req_acc = 8'h00; req_flags = 4'hF;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1", {31'd0, rsp_valid}, 32'd0);
        check(rsp_acc == 8'h01 && rsp_wdata == 8'h9C, "R1", {16'd0, rsp_acc, rsp_wdata},
              {16'd0, 8'h01, 8'h9C});

        // R2 and R3: sweep all opcodes
        legal_cnt = 0;
        long_cnt  = 0;
        for (int op = 0; op < 256; op++) begin
            req_valid = 1'b1; req_opcode = 8'(op); req_mem = 8'h00; req_acc = 8'h00;
            req_flags = 4'h0;
            @(negedge clk);
            if (!rsp_illegal) legal_cnt++;
            if (!rsp_illegal && rsp_len == 2'd3) long_cnt++;
        end
        req_valid = 1'b0;
        check(legal_cnt == 42, "R2", 32'(legal_cnt), 32'd42);
        check(long_cnt == 18, "R3", 32'(long_cnt), 32'd18);

        // R12: reset during an active response clears it
        @(negedge clk);
        drive(VECS[0]);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check(rsp_valid == 1'b0 && rsp_acc == 8'h00 && rsp_wen == 1'b0, "R12",
              {rsp_valid, rsp_wen, rsp_acc}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule